// File: doc/BRIEF.md
# Multiplexed Vacuum Fluorescent Display Grid Scanner

This block time-multiplexes a nine-grid vacuum fluorescent display. Each grid position gets a 4-bit display code. The block turns the selected position's code into an active-low segment pattern (segments a to g plus a decimal point) and pulls that position's grid enable low. The scan steps through the positions in a fixed order. The block makes its own scan-rate tick by dividing the system clock: a prescaler followed by a divider. An enable input can freeze the scan.

Every step begins with all grids turned off. They stay off for a guard interval of a set number of clock cycles. The new segment pattern and the new grid enable are then applied in the same clock cycle. A grid never lights with the segment pattern of the previous digit, so ghosting is suppressed.

There are two special cases. A blank code keeps its grid dark for the whole step. The decimal point is lit at one fixed position and at no other.

Top module: `vfd_scanner`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, all nine `grid_n` lines and all eight `seg_n` lines are high (inactive).
- R2: While `scan_en` is high, a scan step starts every PRESCALE×DIVIDE clock cycles. With the defaults (128×187) and a 12 MHz clock this is about 501 steps per second.
- R3: Successive steps show positions 0, 1, …, 8, and the position after 8 is 0. The first step after reset shows position 0.
- R4: A step starts on the clock edge after the internal tick. From that edge all `grid_n` lines are high for GUARD_CYCLES cycles. After that, exactly one line is low: bit p of `grid_n` for position p. At no time is more than one grid line low.
- R5: `seg_n` changes only on the edge that ends the guard interval, which is the same edge that enables the new grid. During the guard interval `seg_n` keeps the previous pattern.
- R6: Code 10 is the blank code. For a step on a position holding code 10, all `grid_n` lines stay high for the whole step and `seg_n` is all ones.
- R7: `seg_n` bit 0 is segment a, and bits 1 to 6 are segments b to g. Bit 7 is the decimal point. A 0 lights the segment. The lit sets are: code 0 = a,b,c,d,e,f; 1 = b,c; 2 = a,b,d,e,g; 3 = a,b,c,d,g; 4 = b,c,f,g; 5 = a,c,d,f,g; 6 = a,c,d,e,f,g; 7 = a,b,c; 8 = a to g; 9 = a,b,c,d,f,g.
- R8: Code 11 lights only segment g (a dash). Codes 12 to 15 light no segment.
- R9: The decimal point (`seg_n[7]` low) is lit for every non-blank code at position DP_POS (default 1). It is lit at no other position.
- R10: While `scan_en` is low, no step starts and both outputs hold. When `scan_en` returns high, the tick count resumes where it stopped and the scan continues with the next position in sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_en | input | 1 | Scan-rate enable; low freezes the scan |
| codes | input | 36 | Display codes; position p uses bits 4p+3 to 4p |
| seg_n | output | 8 | Active-low segments {dp,g,f,e,d,c,b,a} |
| grid_n | output | 9 | Active-low grid enables, bit p = position p |

## Verification
The assertions assume three things about the parameters and inputs. First, the tick period PRESCALE×DIVIDE is longer than GUARD_CYCLES plus one cycle, so a new tick never arrives while the guard is still counting. Second, `scan_en` changes only while no tick is pending. Third, a position's code is stable on the edge that ends its guard interval. The stimulus meets these conditions as follows. It uses a small divider (2×5) with a 3-cycle guard. It rewrites the codes only right after a position has been shown. It lowers and raises `scan_en` only just after a show edge. Across sixteen rounds it rotates the codes so that every code from 0 to 15 lands on every position, including the blank code on the decimal-point position.

// File: rtl/vfd_pkg.sv
package vfd_pkg;

  localparam int CODE_W   = 4;
  localparam int SEG_W    = 8;

  typedef logic [CODE_W-1:0] code_t;

  localparam code_t CODE_BLANK = 4'd10;
  localparam code_t CODE_DASH  = 4'd11;

  // Lit-segment mask, bit 0 = a ... bit 6 = g (1 = lit).
  function automatic logic [6:0] glyph_lit(input code_t c);
    logic [6:0] m;
    case (c)
      4'd0:    m = 7'b0111111;
      4'd1:    m = 7'b0000110;
      4'd2:    m = 7'b1011011;
      4'd3:    m = 7'b1001111;
      4'd4:    m = 7'b1100110;
      4'd5:    m = 7'b1101101;
      4'd6:    m = 7'b1111101;
      4'd7:    m = 7'b0000111;
      4'd8:    m = 7'b1111111;
      4'd9:    m = 7'b1101111;
      4'd11:   m = 7'b1000000;
      default: m = 7'b0000000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/vfd_scan_tick.sv
module vfd_scan_tick #(
  parameter int PRESCALE = 128,
  parameter int DIVIDE   = 187
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int PW = $clog2(PRESCALE + 1);
  localparam int DW = $clog2(DIVIDE + 1);

  logic [PW-1:0] pre_cnt;
  logic [DW-1:0] div_cnt;
  logic          pre_last, div_last;

  assign pre_last = (pre_cnt == PW'(PRESCALE - 1));
  assign div_last = (div_cnt == DW'(DIVIDE - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      div_cnt <= '0;
      tick    <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (en) begin
        tick <= pre_last && div_last;
        if (pre_last) begin
          pre_cnt <= '0;
          div_cnt <= div_last ? '0 : div_cnt + 1'b1;
        end else begin
          pre_cnt <= pre_cnt + 1'b1;
        end
      end
    end
  end

  // R2: ticks are single-cycle pulses separated by the full period
  p_tick_isolated_r2: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R10: a tick is only produced after an enabled cycle
  p_tick_needs_en_r10: assert property (@(posedge clk) disable iff (rst)
    tick |-> $past(en));

endmodule

// File: rtl/vfd_step_seq.sv
module vfd_step_seq #(
  parameter int NUM_GRIDS    = 9,
  parameter int GUARD_CYCLES = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  output logic [$clog2(NUM_GRIDS)-1:0] pos,
  output logic                         show_go
);
  localparam int PW   = $clog2(NUM_GRIDS);
  localparam int GW   = $clog2(GUARD_CYCLES + 1);
  localparam int LAST = NUM_GRIDS - 1;

  logic [GW-1:0] guard_cnt;
  logic          blanking;

  assign show_go = blanking && (guard_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos       <= PW'(LAST);
      guard_cnt <= '0;
      blanking  <= 1'b0;
    end else if (tick) begin
      pos       <= (pos == PW'(LAST)) ? '0 : pos + 1'b1;
      guard_cnt <= GW'(GUARD_CYCLES - 1);
      blanking  <= 1'b1;
    end else if (blanking) begin
      if (guard_cnt == '0) blanking  <= 1'b0;
      else                 guard_cnt <= guard_cnt - 1'b1;
    end
  end

  // R3: position always in range
  p_pos_range_r3: assert property (@(posedge clk) disable iff (rst)
    pos <= PW'(LAST));

  // R3: wrap from last position to zero
  p_pos_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && pos == PW'(LAST)) |=> (pos == '0));

  // R4: a fresh step always begins with a guard interval
  p_guard_start_r4: assert property (@(posedge clk) disable iff (rst)
    tick |=> (blanking && !show_go) || (GUARD_CYCLES == 1));

endmodule

// File: rtl/vfd_drive.sv
module vfd_drive
  import vfd_pkg::*;
#(
  parameter int NUM_GRIDS = 9,
  parameter int DP_POS    = 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          step_start,
  input  logic                          show_go,
  input  logic [$clog2(NUM_GRIDS)-1:0]  pos,
  input  logic [NUM_GRIDS*CODE_W-1:0]   codes,
  output logic [SEG_W-1:0]              seg_n,
  output logic [NUM_GRIDS-1:0]          grid_n
);
  localparam int PW = $clog2(NUM_GRIDS);
  localparam logic [NUM_GRIDS-1:0] ALL_OFF = '1;

  code_t slot [NUM_GRIDS];

  for (genvar g = 0; g < NUM_GRIDS; g++) begin : g_unpack
    assign slot[g] = codes[g*CODE_W +: CODE_W];
  end

  code_t                 cur;
  logic                  cur_blank;
  logic [SEG_W-1:0]      seg_next;
  logic [NUM_GRIDS-1:0]  grid_next;

  always_comb begin
    cur       = slot[pos];
    cur_blank = (cur == CODE_BLANK);
    if (cur_blank) begin
      seg_next  = '1;
      grid_next = ALL_OFF;
    end else begin
      seg_next  = ~{(pos == PW'(DP_POS)), glyph_lit(cur)};
      grid_next = ~(NUM_GRIDS'(1) << pos);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n  <= '1;
      grid_n <= ALL_OFF;
    end else if (step_start) begin
      grid_n <= ALL_OFF;
    end else if (show_go) begin
      seg_n  <= seg_next;
      grid_n <= grid_next;
    end
  end

  // R4: never more than one grid enabled
  p_one_grid_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~grid_n));

  // R4: every step starts with all grids dark
  p_dark_after_tick_r4: assert property (@(posedge clk) disable iff (rst)
    step_start |=> (grid_n == ALL_OFF));

  // R9: decimal point only with the fixed position's grid
  p_dp_only_pos_r9: assert property (@(posedge clk) disable iff (rst)
    (grid_n != ALL_OFF && grid_n[DP_POS]) |-> seg_n[SEG_W-1]);

  // R5: a grid turns on only at the end of a guard interval
  p_grid_on_after_guard_r5: assert property (@(posedge clk) disable iff (rst)
    (grid_n != ALL_OFF && $past(grid_n) == ALL_OFF) |-> $past(show_go));

endmodule

// File: rtl/vfd_scanner.sv
module vfd_scanner
  import vfd_pkg::*;
#(
  parameter int NUM_GRIDS    = 9,
  parameter int PRESCALE     = 128,
  parameter int DIVIDE       = 187,
  parameter int GUARD_CYCLES = 12,
  parameter int DP_POS       = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        scan_en,
  input  logic [NUM_GRIDS*CODE_W-1:0] codes,
  output logic [SEG_W-1:0]            seg_n,
  output logic [NUM_GRIDS-1:0]        grid_n
);
  localparam int PW = $clog2(NUM_GRIDS);

  logic          tick;
  logic          show_go;
  logic [PW-1:0] pos;

  vfd_scan_tick #(
    .PRESCALE (PRESCALE),
    .DIVIDE   (DIVIDE)
  ) u_tick (
    .clk  (clk),
    .rst  (rst),
    .en   (scan_en),
    .tick (tick)
  );

  vfd_step_seq #(
    .NUM_GRIDS    (NUM_GRIDS),
    .GUARD_CYCLES (GUARD_CYCLES)
  ) u_seq (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .pos     (pos),
    .show_go (show_go)
  );

  vfd_drive #(
    .NUM_GRIDS (NUM_GRIDS),
    .DP_POS    (DP_POS)
  ) u_drive (
    .clk        (clk),
    .rst        (rst),
    .step_start (tick),
    .show_go    (show_go),
    .pos        (pos),
    .codes      (codes),
    .seg_n      (seg_n),
    .grid_n     (grid_n)
  );

  // R1: outputs dark in the first cycle after reset
  p_reset_dark_r1: assert property (@(posedge clk)
    $past(rst) |-> (&seg_n && &grid_n));

endmodule

// File: tb/vfd_scanner_test.sv
`timescale 1ns/1ps
module vfd_scanner_test;
  localparam int NG = 9;
  localparam int P  = 2;
  localparam int D  = 5;
  localparam int G  = 3;
  localparam int N  = P * D;
  localparam int STEPS = 16 * NG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          scan_en = 1'b1;
  logic [NG*4-1:0] codes = '0;
  logic [7:0]    seg_n;
  logic [NG-1:0] grid_n;

  int checks = 0;
  int errors = 0;
  int ecnt   = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vfd_scanner #(
    .NUM_GRIDS(NG), .PRESCALE(P), .DIVIDE(D), .GUARD_CYCLES(G), .DP_POS(1)
  ) uut (
    .clk(clk), .rst(rst), .scan_en(scan_en), .codes(codes),
    .seg_n(seg_n), .grid_n(grid_n)
  );

  always @(posedge clk) if (!rst && scan_en) ecnt <= ecnt + 1;

  function automatic logic [6:0] lit_of(int c);
    case (c)
      0: return 7'h3F;  1: return 7'h06;  2: return 7'h5B;  3: return 7'h4F;
      4: return 7'h66;  5: return 7'h6D;  6: return 7'h7D;  7: return 7'h07;
      8: return 7'h7F;  9: return 7'h6F;  11: return 7'h40;
      default: return 7'h00;
    endcase
  endfunction

  function automatic logic [7:0] exp_seg(int c, int p);
    if (c == 10) return 8'hFF;
    return ~{(p == 1), lit_of(c)};
  endfunction

  function automatic logic [NG-1:0] exp_grid(int c, int p);
    if (c == 10) return '1;
    return ~(NG'(1) << p);
  endfunction

  function automatic int code_at(int p, int r);
    return (p + 3 * r) % 16;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic load_round(int r);
    for (int p = 0; p < NG; p++) codes[p*4 +: 4] = 4'(code_at(p, r));
  endtask

  task automatic at_edge(int n);
    wait (ecnt == n);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin : main
    logic [7:0]    prev_seg;
    logic [NG-1:0] prev_grid;
    load_round(0);
    repeat (3) @(negedge clk);
    chk("R1 grids in reset", 32'(grid_n), 32'h1FF);
    chk("R1 segs in reset", 32'(seg_n), 32'hFF);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 grids after reset", 32'(grid_n), 32'h1FF);
    chk("R1 segs after reset", 32'(seg_n), 32'hFF);
    prev_seg = 8'hFF; prev_grid = '1;
    for (int m = 1; m <= STEPS; m++) begin
      int p, r, c;
      string tag;
      p = (m - 1) % NG; r = (m - 1) / NG; c = code_at(p, r);
      at_edge(m * N);
      chk("R2 previous digit held until tick", 32'(grid_n), 32'(prev_grid));
      at_edge(m * N + 1);
      chk("R4 all grids off at step start", 32'(grid_n), 32'h1FF);
      chk("R5 segments held in guard", 32'(seg_n), 32'(prev_seg));
      at_edge(m * N + G);
      chk("R4 grids off through guard", 32'(grid_n), 32'h1FF);
      chk("R5 segments held to guard end", 32'(seg_n), 32'(prev_seg));
      at_edge(m * N + G + 1);
      if (c == 10)      tag = "R6 blank code";
      else if (c >= 11) tag = "R8 dash/off code";
      else if (p == 1)  tag = "R9 decimal point digit";
      else              tag = "R7 digit glyph";
      chk({tag, " seg"}, 32'(seg_n), 32'(exp_seg(c, p)));
      chk({"R3 position grid ", tag}, 32'(grid_n), 32'(exp_grid(c, p)));
      prev_seg = exp_seg(c, p); prev_grid = exp_grid(c, p);
      if (p == NG - 1) load_round(r + 1);
      if (m == 50) begin
        scan_en = 1'b0;
        for (int k = 0; k < 40; k++) begin
          @(negedge clk);
          chk("R10 grids frozen", 32'(grid_n), 32'(prev_grid));
          chk("R10 segs frozen", 32'(seg_n), 32'(prev_seg));
        end
        scan_en = 1'b1;
      end
    end
    done = 1'b1;
    finish_run();
  end

endmodule